// File: doc/BRIEF.md
# Line Polarity and Supervision Unit

This block sits between the isolated line-phase detector, the line-voltage ADC and the two line-frequency switches of a bridgeless boost rectifier. It cleans the phase square wave with a sampled majority vote and turns it into a polarity bit. It measures the line period in clock cycles and drives the two slow switches of the rectifier leg, one for each half cycle. The two switches are separated by a blanking gap whenever the polarity changes.

Each ADC magnitude sample is compared with two thresholds. A sample below the dead-band threshold holds both switches off until a later sample leaves the dead band. A sample above the overvoltage limit latches a shutdown that also disables the high-frequency PWM elsewhere. The shutdown is released only by reset or by an explicit clear. A period measured outside a programmable window raises a line-fault flag.

Top module: `line_supervisor`

## Requirements
- R1: After reset, `line_pos` is 1, both gates are 0, and `deadband`, `ov_shutdown`, `line_fault`, `period_valid` and `period_cyc` are all 0.
- R2: `phase_raw` is inverted with respect to the line: a high level means the negative half cycle. After `phase_raw` is held at a level for VOTES sample periods, `line_pos` equals its inverse. `line_pos` changes only on a sample tick, which comes every SAMPLE_DIV clocks.
- R3: `line_pos` changes only when a majority of the last VOTES samples (VOTES odd) disagree with it. A pulse on `phase_raw` that covers fewer than (VOTES+1)/2 samples leaves `line_pos` unchanged.
- R4: On each rising edge of `line_pos` after the first, `period_cyc` takes the number of clock cycles since the previous rising edge, and `period_valid` becomes 1.
- R5: `line_fault` is set when a measurement is below `cfg_per_min` or above `cfg_per_max`, or when the running count passes `cfg_per_max`. It is cleared by a measurement inside the window.
- R6: `gate_pos` and `gate_neg` are never 1 together. `gate_pos` is 1 only while `line_pos` is 1, and `gate_neg` only while `line_pos` is 0.
- R7: After a change of `line_pos`, both gates are 0 for exactly BLANK_CYC+1 clock cycles, counted from the first cycle showing the new polarity. The gate for the new half cycle then turns on, provided no dead-band or overvoltage condition holds.
- R8: An `adc_valid` sample with `adc_mag` < `cfg_deadband` sets `deadband` from the next cycle and forces both gates to 0. The next sample at or above the threshold clears it.
- R9: An `adc_valid` sample with `adc_mag` > `cfg_ov_limit` sets `ov_shutdown`, which forces both gates to 0. It stays set through later in-range samples.
- R10: `ov_clr` clears `ov_shutdown`, except in a cycle that also carries an overvoltage sample; in that cycle the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_raw | input | 1 | Isolated phase square wave, high during negative half cycle |
| adc_valid | input | 1 | One-cycle strobe marking a new magnitude sample |
| adc_mag | input | ADC_W | Rectified line-voltage magnitude |
| cfg_deadband | input | ADC_W | Magnitudes below this are in the dead band |
| cfg_ov_limit | input | ADC_W | Magnitudes above this trip the overvoltage latch |
| cfg_per_min | input | PER_W | Shortest acceptable period in clocks |
| cfg_per_max | input | PER_W | Longest acceptable period in clocks |
| ov_clr | input | 1 | Clears the overvoltage latch |
| line_pos | output | 1 | Filtered polarity, 1 = positive half cycle |
| period_cyc | output | PER_W | Last measured line period in clocks |
| period_valid | output | 1 | A period measurement exists |
| line_fault | output | 1 | Period outside the window |
| gate_pos | output | 1 | Line-frequency switch for the positive half |
| gate_neg | output | 1 | Line-frequency switch for the negative half |
| deadband | output | 1 | Last sample was inside the dead band |
| ov_shutdown | output | 1 | Latched overvoltage, PWM disable |

## Verification
The assertions assume that the configuration inputs stay constant while the block runs, that `cfg_per_min` does not exceed `cfg_per_max`, and that `adc_valid` is a single-cycle strobe. The bench sets the thresholds once, before reset is released, and never changes them. It drives each ADC sample for exactly one cycle, starting at a falling clock edge. The phase generator uses half periods whose full period is a whole number of sample ticks, so the filtered edges land at a fixed offset from the raw edges and the measured period equals the generated one exactly.

// File: rtl/lsup_pkg.sv
package lsup_pkg;

    typedef enum logic [1:0] {
        GS_BLANK = 2'd0,
        GS_POS   = 2'd1,
        GS_NEG   = 2'd2
    } gate_st_e;

    typedef struct packed {
        logic in_db;
        logic over_v;
    } adc_chk_t;

    function automatic int unsigned ones_in(input logic [31:0] v);
        int unsigned n;
        n = 0;
        for (int i = 0; i < 32; i++) begin
            n += 32'(v[i]);
        end
        return n;
    endfunction

endpackage

// File: rtl/lsup_vote.sv
module lsup_vote #(
    parameter int VOTES      = 5,
    parameter int SAMPLE_DIV = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic phase_raw,
    output logic pol_pos,
    output logic pol_chg
);
    import lsup_pkg::*;

    localparam int DIV_W = $clog2(SAMPLE_DIV);
    localparam int unsigned HALF = VOTES / 2;

    logic             ph_s1, ph_s2;
    logic [DIV_W-1:0] div_cnt;
    logic             tick;
    logic [VOTES-1:0] hist, nxt_hist;
    logic             want_pos;

    assign tick     = (div_cnt == DIV_W'(SAMPLE_DIV - 1));
    assign nxt_hist = {hist[VOTES-2:0], ph_s2};
    // a high phase level marks the negative half cycle
    assign want_pos = !(ones_in(32'(nxt_hist)) > HALF);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_s1   <= 1'b0;
            ph_s2   <= 1'b0;
            div_cnt <= '0;
            hist    <= '0;
            pol_pos <= 1'b1;
            pol_chg <= 1'b0;
        end else begin
            ph_s1   <= phase_raw;
            ph_s2   <= ph_s1;
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
            pol_chg <= 1'b0;
            if (tick) begin
                hist <= nxt_hist;
                if (want_pos != pol_pos) begin
                    pol_pos <= want_pos;
                    pol_chg <= 1'b1;
                end
            end
        end
    end

    // R2: polarity moves only on a sample tick
    p_pol_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(pol_pos));

endmodule

// File: rtl/lsup_period.sv
module lsup_period #(
    parameter int PER_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pol_pos,
    input  logic [PER_W-1:0] cfg_per_min,
    input  logic [PER_W-1:0] cfg_per_max,
    output logic [PER_W-1:0] period_cyc,
    output logic             period_valid,
    output logic             line_fault
);
    localparam logic [PER_W-1:0] CNT_TOP = '1;

    logic             pol_d;
    logic             armed;
    logic [PER_W-1:0] cnt, cnt_p1;
    logic             rise;

    assign rise   = pol_pos && !pol_d;
    assign cnt_p1 = (cnt == CNT_TOP) ? cnt : cnt + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_d        <= 1'b1;
            armed        <= 1'b0;
            cnt          <= '0;
            period_cyc   <= '0;
            period_valid <= 1'b0;
            line_fault   <= 1'b0;
        end else begin
            pol_d <= pol_pos;
            if (rise) begin
                cnt   <= '0;
                armed <= 1'b1;
                if (armed) begin
                    period_cyc   <= cnt_p1;
                    period_valid <= 1'b1;
                    line_fault   <= (cnt_p1 < cfg_per_min) || (cnt_p1 > cfg_per_max);
                end
            end else begin
                cnt <= cnt_p1;
                if (armed && (cnt_p1 > cfg_per_max)) begin
                    line_fault <= 1'b1;
                end
            end
        end
    end

    // R5: a short measured period raises the fault
    p_short_fault_r5: assert property (@(posedge clk) disable iff (rst)
        rise && armed && (cnt_p1 < cfg_per_min) |=> line_fault);

    // R4: a measurement always marks the period as valid
    p_meas_valid_r4: assert property (@(posedge clk) disable iff (rst)
        rise && armed |=> period_valid);

endmodule

// File: rtl/lsup_gate.sv
module lsup_gate #(
    parameter int ADC_W     = 12,
    parameter int BLANK_CYC = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pol_pos,
    input  logic             pol_chg,
    input  logic             adc_valid,
    input  logic [ADC_W-1:0] adc_mag,
    input  logic [ADC_W-1:0] cfg_deadband,
    input  logic [ADC_W-1:0] cfg_ov_limit,
    input  logic             ov_clr,
    output logic             gate_pos,
    output logic             gate_neg,
    output logic             db_flag,
    output logic             ov_trip
);
    import lsup_pkg::*;

    localparam int BW = $clog2(BLANK_CYC + 1);

    gate_st_e       st;
    logic [BW-1:0]  blank_cnt;
    adc_chk_t       chk;

    assign chk.in_db  = adc_mag < cfg_deadband;
    assign chk.over_v = adc_mag > cfg_ov_limit;

    always_ff @(posedge clk) begin
        if (rst) begin
            db_flag <= 1'b0;
            ov_trip <= 1'b0;
        end else begin
            if (adc_valid) begin
                db_flag <= chk.in_db;
            end
            if (adc_valid && chk.over_v) begin
                ov_trip <= 1'b1;
            end else if (ov_clr) begin
                ov_trip <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= GS_BLANK;
            blank_cnt <= BW'(BLANK_CYC - 1);
        end else if (pol_chg) begin
            st        <= GS_BLANK;
            blank_cnt <= BW'(BLANK_CYC - 1);
        end else begin
            case (st)
                GS_BLANK: begin
                    if (blank_cnt == '0) begin
                        st <= pol_pos ? GS_POS : GS_NEG;
                    end else begin
                        blank_cnt <= blank_cnt - 1'b1;
                    end
                end
                GS_POS, GS_NEG: ;
                default: st <= GS_BLANK;
            endcase
        end
    end

    assign gate_pos = (st == GS_POS) && pol_pos  && !db_flag && !ov_trip;
    assign gate_neg = (st == GS_NEG) && !pol_pos && !db_flag && !ov_trip;

    // R6: the pair is never on together
    p_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(gate_pos && gate_neg));

    // R7: a polarity change blanks both gates in the following cycle
    p_blank_r7: assert property (@(posedge clk) disable iff (rst)
        pol_chg |=> !gate_pos && !gate_neg);

    // R8: a dead-band sample turns both gates off
    p_db_off_r8: assert property (@(posedge clk) disable iff (rst)
        adc_valid && (adc_mag < cfg_deadband) |=> db_flag && !gate_pos && !gate_neg);

    // R9: an overvoltage sample trips the latch
    p_ov_set_r9: assert property (@(posedge clk) disable iff (rst)
        adc_valid && (adc_mag > cfg_ov_limit) |=> ov_trip);

    // R10: without a clear the latch holds
    p_ov_hold_r10: assert property (@(posedge clk) disable iff (rst)
        ov_trip && !ov_clr |=> ov_trip);

endmodule

// File: rtl/line_supervisor.sv
module line_supervisor #(
    parameter int ADC_W      = 12,
    parameter int PER_W      = 24,
    parameter int VOTES      = 5,
    parameter int SAMPLE_DIV = 1000,
    parameter int BLANK_CYC  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             phase_raw,
    input  logic             adc_valid,
    input  logic [ADC_W-1:0] adc_mag,
    input  logic [ADC_W-1:0] cfg_deadband,
    input  logic [ADC_W-1:0] cfg_ov_limit,
    input  logic [PER_W-1:0] cfg_per_min,
    input  logic [PER_W-1:0] cfg_per_max,
    input  logic             ov_clr,
    output logic             line_pos,
    output logic [PER_W-1:0] period_cyc,
    output logic             period_valid,
    output logic             line_fault,
    output logic             gate_pos,
    output logic             gate_neg,
    output logic             deadband,
    output logic             ov_shutdown
);
    logic pol_chg;

    lsup_vote #(.VOTES(VOTES), .SAMPLE_DIV(SAMPLE_DIV)) u_vote (
        .clk       (clk),
        .rst       (rst),
        .phase_raw (phase_raw),
        .pol_pos   (line_pos),
        .pol_chg   (pol_chg)
    );

    lsup_period #(.PER_W(PER_W)) u_period (
        .clk          (clk),
        .rst          (rst),
        .pol_pos      (line_pos),
        .cfg_per_min  (cfg_per_min),
        .cfg_per_max  (cfg_per_max),
        .period_cyc   (period_cyc),
        .period_valid (period_valid),
        .line_fault   (line_fault)
    );

    lsup_gate #(.ADC_W(ADC_W), .BLANK_CYC(BLANK_CYC)) u_gate (
        .clk          (clk),
        .rst          (rst),
        .pol_pos      (line_pos),
        .pol_chg      (pol_chg),
        .adc_valid    (adc_valid),
        .adc_mag      (adc_mag),
        .cfg_deadband (cfg_deadband),
        .cfg_ov_limit (cfg_ov_limit),
        .ov_clr       (ov_clr),
        .gate_pos     (gate_pos),
        .gate_neg     (gate_neg),
        .db_flag      (deadband),
        .ov_trip      (ov_shutdown)
    );

endmodule

// File: tb/line_supervisor_tb.sv
module line_supervisor_tb;
    localparam int ADC_W = 10;
    localparam int PER_W = 16;
    localparam int VOTES = 5;
    localparam int DIV   = 4;
    localparam int BLANK = 8;
    localparam int DB    = 50;
    localparam int OVL   = 900;
    localparam int PMIN  = 60;
    localparam int PMAX  = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic adc_valid = 1'b0;
    logic [ADC_W-1:0] adc_mag = '0;
    logic ov_clr = 1'b0;
    logic gen_on = 1'b0;
    int   gen_h = 40;
    logic ph_gen = 1'b0;
    logic ph_man = 1'b0;
    logic phase_raw;
    logic line_pos, period_valid, line_fault, gate_pos, gate_neg, deadband, ov_shutdown;
    logic [PER_W-1:0] period_cyc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    assign phase_raw = gen_on ? ph_gen : ph_man;

    always #4 clk = ~clk;

    line_supervisor #(.ADC_W(ADC_W), .PER_W(PER_W), .VOTES(VOTES),
                      .SAMPLE_DIV(DIV), .BLANK_CYC(BLANK)) u_dut (
        .clk(clk), .rst(rst), .phase_raw(phase_raw),
        .adc_valid(adc_valid), .adc_mag(adc_mag),
        .cfg_deadband(ADC_W'(DB)), .cfg_ov_limit(ADC_W'(OVL)),
        .cfg_per_min(PER_W'(PMIN)), .cfg_per_max(PER_W'(PMAX)),
        .ov_clr(ov_clr), .line_pos(line_pos), .period_cyc(period_cyc),
        .period_valid(period_valid), .line_fault(line_fault),
        .gate_pos(gate_pos), .gate_neg(gate_neg),
        .deadband(deadband), .ov_shutdown(ov_shutdown)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // phase generator: high H cycles then low H cycles
    initial begin
        forever begin
            if (gen_on) begin
                ph_gen = 1'b1;
                repeat (gen_h) @(negedge clk);
                ph_gen = 1'b0;
                repeat (gen_h) @(negedge clk);
            end else begin
                @(negedge clk);
            end
        end
    end

    task automatic adc_sample(input int m);
        @(negedge clk);
        adc_valid = 1'b1;
        adc_mag   = ADC_W'(m);
        @(negedge clk);
        adc_valid = 1'b0;
    endtask

    task automatic blank_run(input bit to_pos, input string tag);
        int w;
        int n;
        w = 0;
        while (line_pos != to_pos && w < 100) begin
            @(negedge clk);
            w++;
        end
        chk(line_pos == to_pos, tag, int'(line_pos), int'(to_pos));
        n = 0;
        while (!gate_pos && !gate_neg && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == BLANK + 1, {tag, " blank length R7"}, n, BLANK + 1);
        chk(to_pos ? (gate_pos && !gate_neg) : (gate_neg && !gate_pos),
            {tag, " new gate on R6"}, int'({gate_pos, gate_neg}), to_pos ? 2 : 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(line_pos == 1'b1, "R1 line_pos", int'(line_pos), 1);
        chk(!gate_pos && !gate_neg, "R1 gates", int'({gate_pos, gate_neg}), 0);
        chk(!deadband && !ov_shutdown, "R1 flags", int'({deadband, ov_shutdown}), 0);
        chk(!line_fault && !period_valid && period_cyc == 0, "R1 period",
            int'(period_cyc), 0);

        repeat (20) @(negedge clk);
        chk(gate_pos && !gate_neg, "R6 positive gate after reset", int'({gate_pos, gate_neg}), 2);

        // R3: pulse covering two samples must not flip polarity
        begin
            bit moved;
            moved = 1'b0;
            ph_man = 1'b1;
            repeat (2 * DIV) @(negedge clk);
            ph_man = 1'b0;
            repeat (60) begin
                if (!line_pos || !gate_pos) moved = 1'b1;
                @(negedge clk);
            end
            chk(!moved, "R3 short pulse ignored", int'(moved), 0);
        end

        // R2 and R7: steady levels, both directions
        ph_man = 1'b1;
        blank_run(1'b0, "R2 to negative");
        ph_man = 1'b0;
        blank_run(1'b1, "R2 to positive");

        // R4/R5 sweep over half periods; expected period is 2*H
        gen_on = 1'b1;
        for (int h = 24; h <= 64; h += 4) begin
            int expp;
            gen_h = h;
            repeat (400 + 6 * h) @(negedge clk);
            expp = 2 * h;
            chk(period_valid, "R4 period_valid", int'(period_valid), 1);
            chk(int'(period_cyc) == expp, "R4 period", int'(period_cyc), expp);
            chk(line_fault == ((expp < PMIN) || (expp > PMAX)), "R5 window fault",
                int'(line_fault), int'((expp < PMIN) || (expp > PMAX)));
        end
        gen_h = 40;
        repeat (800) @(negedge clk);
        chk(!line_fault && period_cyc == 80, "R5 fault cleared", int'(line_fault), 0);
        gen_on = 1'b0;
        repeat (100) @(negedge clk);
        chk(line_pos && gate_pos, "R6 settled positive", int'({line_pos, gate_pos}), 3);

        // R8 dead-band sweep below the overvoltage limit
        for (int m = 0; m <= OVL; m += 7) begin
            adc_sample(m);
            chk(deadband == (m < DB), "R8 deadband flag", int'(deadband), int'(m < DB));
            chk(gate_pos == !(m < DB) && !gate_neg, "R8 gate", int'(gate_pos), int'(!(m < DB)));
            chk(!ov_shutdown, "R9 no trip in range", int'(ov_shutdown), 0);
        end
        adc_sample(DB - 1);
        chk(deadband && !gate_pos, "R8 boundary below", int'(deadband), 1);
        adc_sample(DB);
        chk(!deadband && gate_pos, "R8 boundary at threshold", int'(deadband), 0);

        // R9 overvoltage latch
        adc_sample(OVL);
        chk(!ov_shutdown, "R9 at limit", int'(ov_shutdown), 0);
        adc_sample(OVL + 1);
        chk(ov_shutdown && !gate_pos && !gate_neg, "R9 trip", int'(ov_shutdown), 1);
        adc_sample(500);
        chk(ov_shutdown && !gate_pos, "R9 latched", int'(ov_shutdown), 1);

        // R10 clear priority
        @(negedge clk);
        ov_clr = 1'b1;
        adc_sample(950);
        ov_clr = 1'b0;
        chk(ov_shutdown, "R10 set wins over clear", int'(ov_shutdown), 1);
        @(negedge clk);
        ov_clr = 1'b1;
        @(negedge clk);
        ov_clr = 1'b0;
        chk(!ov_shutdown, "R10 clear", int'(ov_shutdown), 0);
        adc_sample(500);
        chk(gate_pos && !gate_neg, "R10 gate restored", int'(gate_pos), 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule